// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block is the front end of a pipelined processor. In each cycle it may send the program counter to an instruction cache port. When the cache reports a hit, the block cuts a group of consecutive instructions out of the returned line. It then presents them to decode in numbered slots. Each slot carries the instruction word, its address, a predicted next address, and a value from a global sequence counter. Branches are always predicted not-taken, so the predicted next address of every slot is that slot's address plus four.

Later pipeline stages send signals back to the block: two squash requests with redirect targets, a "commit still squashing" level, and four stall levels. A six-state machine handles these by priority. The states are IDLE, RUN, BLOCKED, SQUASHING, MISS_WAIT and MISS_DONE. The same machine also tracks cache-miss waits and access faults. A fault raises a one-cycle trap request. The transitions are as follows:

- **Reset:** leads to IDLE.
- **IDLE, RUN or MISS_DONE:**
  - A squash goes to SQUASHING.
  - A stall goes to BLOCKED.
  - A fault goes to BLOCKED.
  - A miss goes to MISS_WAIT.
  - A delivered group goes to RUN.
- **BLOCKED:**
  - It returns to RUN when every stall is low.
  - A squash takes it to SQUASHING.
- **SQUASHING:** it goes to RUN once neither the commit squash nor the busy level is high.
- **MISS_WAIT:** the fill response takes it to MISS_DONE.

Top module: `fetch_stage_ctrl`

## Requirements
- R1: After reset the state is IDLE (code 0), the PC is RESET_PC, the next PC is RESET_PC+4, no slot is valid, and the first delivered slot carries sequence number 0. State codes: IDLE=0, RUN=1, BLOCKED=2, SQUASHING=3, MISS_WAIT=4, MISS_DONE=5.
- R2: In IDLE, RUN, MISS_DONE or BLOCKED, only the highest-priority backward condition acts. The order is: commit squash, then decode squash, then commit busy, then any stall.
- R3: A squash loads the PC with its target and the next PC with the target plus 4. It enters SQUASHING. In that cycle it issues no cache request and delivers no slots.
- R4: SQUASHING returns to RUN only in a cycle where both the commit squash and commit busy are low. A commit squash that arrives in SQUASHING reloads the PC. A decode squash in SQUASHING has no effect.
- R5: Any of the four stall inputs high (with no squash or busy) gives BLOCKED with no slots and the PC unchanged. BLOCKED returns to RUN once all stalls are low. A squash is still taken in BLOCKED.
- R6: A request without hit or fault enters MISS_WAIT. The fill response moves it to MISS_DONE. MISS_DONE delivers the group from the buffered fill line without raising a cache request, and then goes to RUN.
- R7: A fill response that arrives in any state other than MISS_WAIT is ignored. It causes no state change and no delivery.
- R8: A group holds min(FETCH_W, words left in the 64-byte line from the PC) instructions. The valid mask has slot 0 upward set.
- R9: After a group, the PC is the address just past the last fetched instruction, and the next PC is that address plus 4.
- R10: Slot k carries these values:
  - instruction word w = PC[5:2]+k of the line, taken from line bits [32w+31:32w];
  - address PC+4k;
  - predicted address PC+4k+4;
  - sequence base+k.
  The sequence base then advances by the group size.
- R11: A fault on a cache request enters BLOCKED. It leaves the PC unchanged, delivers no slots, and pulses the trap request output for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sq_commit | input | 1 | Squash request from commit |
| sq_commit_pc | input | 32 | Redirect target from commit |
| sq_decode | input | 1 | Squash request from decode |
| sq_decode_pc | input | 32 | Redirect target from decode |
| commit_busy | input | 1 | Commit is still squashing |
| stall_dec | input | 1 | Stall from decode |
| stall_ren | input | 1 | Stall from rename |
| stall_exe | input | 1 | Stall from execute |
| stall_cmt | input | 1 | Stall from commit |
| ic_req_valid | output | 1 | Cache access request |
| ic_req_addr | output | 32 | Access address (current PC) |
| ic_hit | input | 1 | Same-cycle hit for the request |
| ic_fault | input | 1 | Same-cycle fault for the request |
| ic_line | input | 512 | Line data on a hit |
| ic_fill_valid | input | 1 | Miss fill response pulse |
| ic_fill_line | input | 512 | Line data with the fill |
| slot_valid | output | 4 | Per-slot valid mask |
| slot_inst | output | 128 | Instruction words, slot k at [32k+31:32k] |
| slot_pc | output | 128 | Slot addresses |
| slot_pred_pc | output | 128 | Predicted next addresses |
| slot_seq | output | 64 | Sequence numbers, 16 bits per slot |
| pc | output | 32 | Current PC |
| next_pc | output | 32 | Current next PC |
| trap_req | output | 1 | One-cycle trap request after a fault |
| fsm_state | output | 3 | Controller state code |

## Verification
Some properties are checked by assertions on every cycle:
- MISS_DONE is never entered except from MISS_WAIT.
- A commit squash in a fetching state always lands in SQUASHING at its target.
- A lone stall always yields BLOCKED with empty slots.
- MISS_DONE never raises a cache request.
- The valid mask is always contiguous from slot 0.
- The trap request only appears together with BLOCKED.

Other behaviour is shown only by the bench's directed scenarios: the exact slot contents and sequence numbering across groups, the group truncated at the line end, the full priority ladder, the exit from SQUASHING, and fill responses ignored outside MISS_WAIT.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int INST_W     = 32;
    localparam int INST_BYTES = 4;
    localparam int LINE_BYTES = 64;
    localparam int FETCH_W    = 4;
    localparam int SEQ_W      = 16;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RUN       = 3'd1,
        ST_BLOCKED   = 3'd2,
        ST_SQUASHING = 3'd3,
        ST_MISS_WAIT = 3'd4,
        ST_MISS_DONE = 3'd5
    } fetch_state_e;
endpackage

// File: rtl/fetch_seq_counter.sv
module fetch_seq_counter #(
    parameter int SEQ_W = 16,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] amount,
    output logic [SEQ_W-1:0] seq_base
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_base <= '0;
        else if (adv)
            seq_base <= seq_base + SEQ_W'(amount);
    end
endmodule

// File: rtl/fetch_group_builder.sv
module fetch_group_builder #(
    parameter int INST_W     = 32,
    parameter int INST_BYTES = 4,
    parameter int LINE_BYTES = 64,
    parameter int FETCH_W    = 4,
    parameter int SEQ_W      = 16,
    localparam int WORDS     = LINE_BYTES / INST_BYTES,
    localparam int IDX_W     = $clog2(WORDS),
    localparam int OFF_W     = $clog2(INST_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int CNT_W     = $clog2(FETCH_W + 1)
) (
    input  logic [31:0]               grp_pc,
    input  logic [LINE_W-1:0]         line,
    input  logic [SEQ_W-1:0]          seq_base,
    output logic [FETCH_W-1:0]        valid,
    output logic [FETCH_W*INST_W-1:0] insts,
    output logic [FETCH_W*32-1:0]     pcs,
    output logic [FETCH_W*32-1:0]     preds,
    output logic [FETCH_W*SEQ_W-1:0]  seqs,
    output logic [CNT_W-1:0]          count,
    output logic [31:0]               after_pc
);
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W:0]   room;

    assign start_idx = grp_pc[OFF_W +: IDX_W];
    assign room      = (IDX_W+1)'(WORDS) - {1'b0, start_idx};
    assign count     = (room < (IDX_W+1)'(FETCH_W)) ? CNT_W'(room) : CNT_W'(FETCH_W);
    assign after_pc  = grp_pc + (32'(count) << OFF_W);

    for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
        logic [IDX_W-1:0] widx;
        assign widx  = start_idx + IDX_W'(k);
        assign valid[k] = (CNT_W'(k) < count);
        assign insts[k*INST_W +: INST_W] = valid[k] ? line[widx*INST_W +: INST_W] : '0;
        assign pcs[k*32 +: 32]   = grp_pc + 32'(k * INST_BYTES);
        assign preds[k*32 +: 32] = grp_pc + 32'((k + 1) * INST_BYTES);
        assign seqs[k*SEQ_W +: SEQ_W] = seq_base + SEQ_W'(k);
    end
endmodule

// File: rtl/fetch_stage_ctrl.sv
module fetch_stage_ctrl
    import fetch_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_1000,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int CNT_W  = $clog2(FETCH_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sq_commit,
    input  logic [31:0]               sq_commit_pc,
    input  logic                      sq_decode,
    input  logic [31:0]               sq_decode_pc,
    input  logic                      commit_busy,
    input  logic                      stall_dec,
    input  logic                      stall_ren,
    input  logic                      stall_exe,
    input  logic                      stall_cmt,
    output logic                      ic_req_valid,
    output logic [31:0]               ic_req_addr,
    input  logic                      ic_hit,
    input  logic                      ic_fault,
    input  logic [LINE_W-1:0]         ic_line,
    input  logic                      ic_fill_valid,
    input  logic [LINE_W-1:0]         ic_fill_line,
    output logic [FETCH_W-1:0]        slot_valid,
    output logic [FETCH_W*INST_W-1:0] slot_inst,
    output logic [FETCH_W*32-1:0]     slot_pc,
    output logic [FETCH_W*32-1:0]     slot_pred_pc,
    output logic [FETCH_W*SEQ_W-1:0]  slot_seq,
    output logic [31:0]               pc,
    output logic [31:0]               next_pc,
    output logic                      trap_req,
    output logic [2:0]                fsm_state
);
    fetch_state_e state, state_n;
    logic [31:0]       pc_n;
    logic              deliver, use_buf, trap_n;
    logic              any_stall;
    logic [LINE_W-1:0] fill_buf;
    logic [SEQ_W-1:0]  seq_base;

    logic [FETCH_W-1:0]        g_valid;
    logic [FETCH_W*INST_W-1:0] g_inst;
    logic [FETCH_W*32-1:0]     g_pc, g_pred;
    logic [FETCH_W*SEQ_W-1:0]  g_seq;
    logic [CNT_W-1:0]          g_count;
    logic [31:0]               g_after;

    assign any_stall   = stall_dec | stall_ren | stall_exe | stall_cmt;
    assign ic_req_addr = pc;
    assign fsm_state   = state;

    fetch_group_builder #(
        .INST_W(INST_W), .INST_BYTES(INST_BYTES), .LINE_BYTES(LINE_BYTES),
        .FETCH_W(FETCH_W), .SEQ_W(SEQ_W)
    ) u_group (
        .grp_pc(pc), .line(use_buf ? fill_buf : ic_line), .seq_base(seq_base),
        .valid(g_valid), .insts(g_inst), .pcs(g_pc), .preds(g_pred),
        .seqs(g_seq), .count(g_count), .after_pc(g_after)
    );

    fetch_seq_counter #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(deliver), .amount(g_count),
        .seq_base(seq_base)
    );

    // Next-state and PC selection
    always_comb begin
        state_n      = state;
        pc_n         = pc;
        deliver      = 1'b0;
        use_buf      = 1'b0;
        trap_n       = 1'b0;
        ic_req_valid = 1'b0;
        unique case (state)
            ST_IDLE, ST_RUN, ST_MISS_DONE: begin
                if (sq_commit) begin
                    state_n = ST_SQUASHING;
                    pc_n    = sq_commit_pc;
                end else if (sq_decode) begin
                    state_n = ST_SQUASHING;
                    pc_n    = sq_decode_pc;
                end else if (commit_busy) begin
                    state_n = ST_SQUASHING;
                end else if (any_stall) begin
                    state_n = ST_BLOCKED;
                end else if (state == ST_MISS_DONE) begin
                    deliver = 1'b1;
                    use_buf = 1'b1;
                    state_n = ST_RUN;
                end else begin
                    ic_req_valid = 1'b1;
                    if (ic_fault) begin
                        state_n = ST_BLOCKED;
                        trap_n  = 1'b1;
                    end else if (ic_hit) begin
                        deliver = 1'b1;
                        state_n = ST_RUN;
                    end else begin
                        state_n = ST_MISS_WAIT;
                    end
                end
            end
            ST_BLOCKED: begin
                if (!any_stall) state_n = ST_RUN;
                if (sq_commit) begin
                    state_n = ST_SQUASHING;
                    pc_n    = sq_commit_pc;
                end else if (sq_decode) begin
                    state_n = ST_SQUASHING;
                    pc_n    = sq_decode_pc;
                end else if (commit_busy) begin
                    state_n = ST_SQUASHING;
                end
            end
            ST_SQUASHING: begin
                if (!sq_commit && !commit_busy) state_n = ST_RUN;
                else if (sq_commit)             pc_n    = sq_commit_pc;
            end
            ST_MISS_WAIT: begin
                if (ic_fill_valid) state_n = ST_MISS_DONE;
            end
            default: state_n = ST_IDLE;
        endcase
        if (deliver) pc_n = g_after;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pc      <= RESET_PC;
            next_pc <= RESET_PC + 32'(INST_BYTES);
        end else begin
            state   <= state_n;
            pc      <= pc_n;
            next_pc <= pc_n + 32'(INST_BYTES);
        end
    end

    // Output and fill-buffer register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid   <= '0;
            slot_inst    <= '0;
            slot_pc      <= '0;
            slot_pred_pc <= '0;
            slot_seq     <= '0;
            trap_req     <= 1'b0;
            fill_buf     <= '0;
        end else begin
            slot_valid   <= deliver ? g_valid : '0;
            slot_inst    <= g_inst;
            slot_pc      <= g_pc;
            slot_pred_pc <= g_pred;
            slot_seq     <= g_seq;
            trap_req     <= trap_n;
            if (state == ST_MISS_WAIT && ic_fill_valid) fill_buf <= ic_fill_line;
        end
    end

    logic fetching;
    assign fetching = (state == ST_IDLE) || (state == ST_RUN) || (state == ST_MISS_DONE);

    p_fill_only_in_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MISS_WAIT) |=> (state != ST_MISS_DONE));
    p_commit_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && sq_commit) |=> (state == ST_SQUASHING && pc == $past(sq_commit_pc)
                                     && slot_valid == '0));
    p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetching && !sq_commit && !sq_decode && !commit_busy && any_stall)
        |=> (state == ST_BLOCKED && slot_valid == '0 && $stable(pc)));
    p_done_no_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MISS_DONE) |-> !ic_req_valid);
    p_mask_contiguous_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_valid + 1'b1) & slot_valid) == '0);
    p_trap_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (state == ST_BLOCKED && slot_valid == '0));
endmodule

// File: tb/tb_fetch_stage_ctrl.sv
module tb_fetch_stage_ctrl;
    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sq_commit = 0, sq_decode = 0, commit_busy = 0;
    logic [31:0] sq_commit_pc = '0, sq_decode_pc = '0;
    logic stall_dec = 0, stall_ren = 0, stall_exe = 0, stall_cmt = 0;
    logic ic_req_valid;
    logic [31:0] ic_req_addr;
    logic ic_hit = 0, ic_fault = 0, ic_fill_valid = 0;
    logic [511:0] ic_line, ic_fill_line;
    logic [31:0] fill_base = '0;
    logic [3:0] slot_valid;
    logic [127:0] slot_inst, slot_pc, slot_pred_pc;
    logic [63:0] slot_seq;
    logic [31:0] pc, next_pc;
    logic trap_req;
    logic [2:0] fsm_state;

    int checks = 0;
    int fails  = 0;
    int exp_seq = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return a ^ 32'hC0DE_0000;
    endfunction

    always_comb begin
        for (int i = 0; i < 16; i++) begin
            ic_line[i*32 +: 32]      = word_at({ic_req_addr[31:6], 6'b0} + 32'(i*4));
            ic_fill_line[i*32 +: 32] = word_at({fill_base[31:6], 6'b0} + 32'(i*4));
        end
    end

    fetch_stage_ctrl #(.RESET_PC(RST_PC)) dut (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // Check a full group starting at base of n slots
    task automatic chk_group(input string req, input logic [31:0] base, input int n);
        chk(req, slot_valid, (4'b1 << n) - 4'b1);
        for (int k = 0; k < n; k++) begin
            chk(req, slot_inst[k*32 +: 32], word_at(base + 32'(4*k)));
            chk(req, slot_pc[k*32 +: 32], base + 32'(4*k));
            chk(req, slot_pred_pc[k*32 +: 32], base + 32'(4*k + 4));
            chk(req, slot_seq[k*16 +: 16], 16'(exp_seq + k));
        end
        exp_seq += n;
        chk(req, pc, base + 32'(4*n));
        chk(req, next_pc, base + 32'(4*n + 4));
    endtask

    task automatic redirect(input logic [31:0] tgt);
        sq_commit = 1; sq_commit_pc = tgt;
        tick;
        sq_commit = 0;
        tick;
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (2) tick;
        chk("R1 state", fsm_state, 0);
        chk("R1 pc", pc, RST_PC);
        chk("R1 npc", next_pc, RST_PC + 4);
        chk("R1 valid", slot_valid, 0);
        rst_n = 1;
    endtask

    task automatic t_hit_group;
        ic_hit = 1;
        tick;
        chk("R1 state run", fsm_state, 1);
        chk_group("R10 R9 first group", RST_PC, 4);
        tick;
        chk_group("R10 second group", RST_PC + 16, 4);
    endtask

    task automatic t_line_end;
        redirect(32'h0000_2038);
        chk("R4 back to run", fsm_state, 1);
        chk("R3 no slots", slot_valid, 0);
        tick;
        chk_group("R8 line end group", 32'h0000_2038, 2);
        tick;
        chk_group("R8 next line group", 32'h0000_2040, 4);
    endtask

    task automatic t_priority;
        logic [31:0] p0;
        sq_commit = 1; sq_commit_pc = 32'h3000;
        sq_decode = 1; sq_decode_pc = 32'h4000;
        commit_busy = 1; stall_exe = 1;
        tick;
        chk("R2 commit wins pc", pc, 32'h3000);
        chk("R3 npc", next_pc, 32'h3004);
        chk("R3 state", fsm_state, 3);
        chk("R3 no request slots", slot_valid, 0);
        sq_commit = 0; sq_decode = 0; commit_busy = 0; stall_exe = 0;
        tick;
        chk("R4 exit", fsm_state, 1);
        sq_decode = 1; commit_busy = 1; stall_dec = 1;
        tick;
        chk("R2 decode over busy pc", pc, 32'h4000);
        chk("R2 decode state", fsm_state, 3);
        sq_decode = 0; commit_busy = 0; stall_dec = 0;
        tick;
        p0 = pc;
        commit_busy = 1; stall_cmt = 1;
        tick;
        chk("R2 busy over stall", fsm_state, 3);
        chk("R2 pc kept", pc, p0);
        commit_busy = 0; stall_cmt = 0;
        tick;
        chk("R4 exit again", fsm_state, 1);
    endtask

    task automatic t_squashing;
        commit_busy = 1;
        tick;
        chk("R4 enter", fsm_state, 3);
        sq_decode = 1; sq_decode_pc = 32'h7000;
        tick;
        chk("R4 decode ignored state", fsm_state, 3);
        chk("R4 decode ignored pc", pc, 32'h4000);
        sq_decode = 0; commit_busy = 0; sq_commit = 1; sq_commit_pc = 32'h5000;
        tick;
        chk("R4 reload pc", pc, 32'h5000);
        chk("R4 stays", fsm_state, 3);
        sq_commit = 0;
        tick;
        chk("R4 leaves", fsm_state, 1);
        tick;
        chk_group("R9 after squash group", 32'h5000, 4);
    endtask

    task automatic t_stall;
        stall_ren = 1;
        tick;
        chk("R5 blocked", fsm_state, 2);
        chk("R5 no slots", slot_valid, 0);
        chk("R5 pc held", pc, 32'h5010);
        ic_fill_valid = 1; fill_base = 32'h5000;
        tick;
        ic_fill_valid = 0;
        chk("R7 fill ignored blocked", fsm_state, 2);
        chk("R7 no slots", slot_valid, 0);
        stall_ren = 0;
        tick;
        chk("R5 resume", fsm_state, 1);
        tick;
        chk_group("R5 fetch after resume", 32'h5010, 4);
        stall_exe = 1;
        tick;
        sq_decode = 1; sq_decode_pc = 32'h6000;
        tick;
        chk("R5 squash in blocked", fsm_state, 3);
        chk("R5 squash pc", pc, 32'h6000);
        sq_decode = 0; stall_exe = 0;
        tick;
    endtask

    task automatic t_miss;
        ic_hit = 0;
        tick;
        chk("R6 wait", fsm_state, 4);
        chk("R6 pc held", pc, 32'h6000);
        tick;
        chk("R6 still wait", fsm_state, 4);
        ic_fill_valid = 1; fill_base = 32'h6000;
        tick;
        ic_fill_valid = 0;
        chk("R6 done", fsm_state, 5);
        chk("R6 no request", ic_req_valid, 0);
        tick;
        chk("R6 run", fsm_state, 1);
        chk_group("R6 delivered from fill", 32'h6000, 4);
        ic_fill_valid = 1;
        ic_hit = 1;
        tick;
        ic_fill_valid = 0;
        chk("R7 fill ignored run", fsm_state, 1);
        chk_group("R7 normal group", 32'h6010, 4);
    endtask

    task automatic t_fault;
        ic_fault = 1;
        tick;
        ic_fault = 0;
        chk("R11 blocked", fsm_state, 2);
        chk("R11 trap", trap_req, 1);
        chk("R11 pc", pc, 32'h6020);
        chk("R11 no slots", slot_valid, 0);
        tick;
        chk("R11 trap one cycle", trap_req, 0);
        chk("R11 resume", fsm_state, 1);
        tick;
        chk_group("R11 refetch", 32'h6020, 4);
    endtask

    initial begin
        t_reset;
        t_hit_group;
        t_line_end;
        t_priority;
        t_squashing;
        t_stall;
        t_miss;
        t_fault;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule